// File: doc/BRIEF.md
# Dual-Side Integration Conversion Sequencer

This block sequences an integrating current front end that owns two integrators, side A and side B. One side integrates while the other is measured, then the roles swap. The block reads a conversion strobe (`conv`) and a busy flag (`busy`) from a separate measure/reset/auto-zero engine. It drives the integrating-side select, a one-clock measurement-start pulse, a data-valid pulse tagged with the measured side, and the number of the current state.

Eight states cover non-continuous operation. States 1 and 8 wait on the busy flag alone. States 4 and 5 launch a measurement and wait for the engine to answer. States 2, 3, 6 and 7 follow the level of `conv`. Only the level of `conv` counts, not its edges, so many `conv` waveforms give the same state sequence. No state has a minimum dwell. The only guard is an optional warning that the preparation state (2 or 7) was shorter than a set number of clocks. Setting `INVERT_CONV` selects the mirrored group, states 5 to 8. That group reads `conv` with the opposite polarity and starts with side B integrating.

Top module: `dualside_conv_seq`

## Requirements
- R1: Asserting `rst_n` low clears the block at once, without waiting for a clock: `state_num` reads 1 (8 when `INVERT_CONV`=1), `int_side` reads side A (side B when `INVERT_CONV`=1), and `meas_start`, `dvalid`, `meas_side` and `short_prep` read 0. Release is synchronised to `clk`. Side encoding is 0 = A and 1 = B.
- R2: In state 1 (or 8), the block stays put on every clock where `busy` is sampled high, whatever `conv` does. On the first clock `busy` is sampled low, it moves to state 2 (or 7).
- R3: State 2 moves to state 3 on the first clock `conv` is sampled high, even if that is the first clock spent in state 2. It stays in state 2 while `conv` is low.
- R4: State 3 stays while `conv` is high and moves to state 4 on the first clock `conv` is sampled low.
- R5: Entering state 4 (or 5) makes `meas_start` high for exactly one clock and toggles `int_side`. The block stays in state 4 (or 5) while `busy` is low, whatever `conv` does. It goes to state 1 (or 8) on the first clock `busy` is sampled high.
- R6: When the block leaves state 1 (or 8) after a launched measurement, `dvalid` goes high for exactly one clock, together with the arrival in state 2 (or 7). At that point `meas_side` gives the side that was integrating before the last launch. The first exit after reset gives no `dvalid`.
- R7: With `INVERT_CONV`=1, states 8, 7, 6 and 5 take the roles of states 1, 2, 3 and 4 with `conv` read inverted. State 7 advances when `conv` is low. State 6 advances when `conv` is high.
- R8: On the clock after the block leaves state 2 (or 7), `short_prep` is high for one clock if the state lasted fewer than `MIN_PREP_CLKS` clocks (default 16). With exactly `MIN_PREP_CLKS` clocks it stays low. With `WARN_EN`=0 it is always 0.
- R9: `state_num` is the current state number as an unsigned 4-bit value from 1 to 8. After reset the state order for a square-wave `conv` repeats 3, 4, 1, 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| conv | input | 1 | Conversion strobe level |
| busy | input | 1 | Busy flag of the measure/reset/auto-zero engine |
| int_side | output | 1 | Side now integrating (0 = A, 1 = B) |
| meas_start | output | 1 | One-clock request to start a measurement |
| dvalid | output | 1 | One-clock pulse: measured data is ready |
| meas_side | output | 1 | Side whose data the last measurement carries |
| short_prep | output | 1 | One-clock warning: preparation state was too short |
| state_num | output | 4 | Current state number, 1 to 8 |

## Verification
The hardest case to reach from the ports is a preparation state that sits exactly on the warning limit. The bench releases `busy` with `conv` low, holds `conv` low for a counted number of clocks, then raises it. It does this once for 15 clocks and once for 16, so the dwell lands on each side of the limit. The bench also raises `conv` before `busy` falls, which pushes the block through a one-clock state 2. It toggles `conv` inside the busy-wait and launch states to show those states ignore it. A second instance built with the inverted group runs the mirrored sequence.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [3:0] {
    ST_WAIT_N   = 4'd1,
    ST_PREP_N   = 4'd2,
    ST_INTEG_N  = 4'd3,
    ST_LAUNCH_N = 4'd4,
    ST_LAUNCH_I = 4'd5,
    ST_INTEG_I  = 4'd6,
    ST_PREP_I   = 4'd7,
    ST_WAIT_I   = 4'd8
  } dsc_state_e;

  localparam logic SIDE_A = 1'b0;
  localparam logic SIDE_B = 1'b1;

  function automatic logic is_wait(input dsc_state_e s);
    return (s == ST_WAIT_N) || (s == ST_WAIT_I);
  endfunction

  function automatic logic is_prep(input dsc_state_e s);
    return (s == ST_PREP_N) || (s == ST_PREP_I);
  endfunction

  function automatic logic is_launch(input dsc_state_e s);
    return (s == ST_LAUNCH_N) || (s == ST_LAUNCH_I);
  endfunction

endpackage

// File: rtl/dsc_fsm.sv
module dsc_fsm
  import dsc_pkg::*;
#(
  parameter bit INVERT_CONV = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv,
  input  logic       busy,
  output dsc_state_e state_q,
  output logic       launch_enter,
  output logic       wait_exit,
  output logic       prep_enter,
  output logic       prep_exit,
  output logic       in_prep
);

  localparam dsc_state_e RESET_ST = INVERT_CONV ? ST_WAIT_I : ST_WAIT_N;

  dsc_state_e state_d;
  logic       state_en;

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_N:   if (!busy) state_d = ST_PREP_N;
      ST_PREP_N:   if (conv)  state_d = ST_INTEG_N;
      ST_INTEG_N:  if (!conv) state_d = ST_LAUNCH_N;
      ST_LAUNCH_N: if (busy)  state_d = ST_WAIT_N;
      ST_WAIT_I:   if (!busy) state_d = ST_PREP_I;
      ST_PREP_I:   if (!conv) state_d = ST_INTEG_I;
      ST_INTEG_I:  if (conv)  state_d = ST_LAUNCH_I;
      ST_LAUNCH_I: if (busy)  state_d = ST_WAIT_I;
      default:                state_d = RESET_ST;
    endcase
  end

  assign state_en = (state_d != state_q);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RESET_ST;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign in_prep      = is_prep(state_q);
  assign launch_enter = state_en && is_launch(state_d);
  assign wait_exit    = state_en && is_wait(state_q);
  assign prep_enter   = state_en && is_prep(state_d);
  assign prep_exit    = state_en && in_prep;

  // R2: busy-wait state holds while busy is high
  p_wait_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wait(state_q) && busy) |=> (state_q == $past(state_q)));

  // R3: prep state leaves on the first high conv sample
  p_prep_leave_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PREP_N && conv) |=> (state_q == ST_INTEG_N));

  // R4: integrate state holds while conv is high
  p_integ_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INTEG_N && conv) |=> (state_q == ST_INTEG_N));

  // R5: launch state ignores conv while busy is low
  p_launch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_launch(state_q) && !busy) |=> (state_q == $past(state_q)));

  // R7: mirrored prep state leaves on a low conv sample
  p_mirror_prep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PREP_I && !conv) |=> (state_q == ST_INTEG_I));

endmodule

// File: rtl/dsc_prep_timer.sv
module dsc_prep_timer #(
  parameter int unsigned MIN_PREP_CLKS = 16,
  parameter bit          WARN_EN       = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_prep,
  input  logic prep_enter,
  input  logic prep_exit,
  output logic short_prep
);

  localparam int unsigned CW = $clog2(MIN_PREP_CLKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_PREP_CLKS);

  logic [CW-1:0] dwell_q, dwell_d;
  logic          dwell_en;
  logic          warn_q, warn_d;

  always_comb begin
    dwell_en = 1'b0;
    dwell_d  = dwell_q;
    if (prep_enter) begin
      dwell_en = 1'b1;
      dwell_d  = CW'(1);
    end else if (in_prep && !prep_exit && (dwell_q < LIMIT)) begin
      dwell_en = 1'b1;
      dwell_d  = dwell_q + CW'(1);
    end
    warn_d = prep_exit && (dwell_q < LIMIT) && WARN_EN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwell_q <= '0;
    end else if (dwell_en) begin
      dwell_q <= dwell_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
    end else begin
      warn_q <= warn_d;
    end
  end

  assign short_prep = warn_q;

  // R8: warning is a single-clock pulse
  p_warn_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    short_prep |=> !short_prep);

  // R8: warning only follows a prep state
  p_warn_after_prep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    short_prep |-> $past(in_prep));

endmodule

// File: rtl/dsc_side_track.sv
module dsc_side_track #(
  parameter logic INIT_SIDE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_enter,
  input  logic wait_exit,
  output logic int_side,
  output logic meas_side,
  output logic meas_start,
  output logic dvalid
);

  logic side_q, mside_q, start_q, dv_q, pend_q;
  logic side_en, pend_d, pend_en;

  always_comb begin
    side_en = launch_enter;
    pend_en = launch_enter || wait_exit;
    pend_d  = launch_enter;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_q  <= INIT_SIDE;
      mside_q <= 1'b0;
    end else if (side_en) begin
      side_q  <= ~side_q;
      mside_q <= side_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dv_q    <= 1'b0;
    end else begin
      start_q <= launch_enter;
      dv_q    <= wait_exit && pend_q;
    end
  end

  assign int_side   = side_q;
  assign meas_side  = mside_q;
  assign meas_start = start_q;
  assign dvalid     = dv_q;

  // R5: start request lasts one clock
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start |=> !meas_start);

  // R5: each start swaps the integrating side
  p_side_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start |-> (int_side != $past(int_side)));

  // R6: data-valid lasts one clock
  p_dv_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |=> !dvalid);

  // R6: reported side is the one swapped out
  p_dv_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> (meas_side != int_side));

endmodule

// File: rtl/dualside_conv_seq.sv
module dualside_conv_seq
  import dsc_pkg::*;
#(
  parameter bit          INVERT_CONV     = 1'b0,
  parameter int unsigned MIN_PREP_CLKS   = 16,
  parameter bit          WARN_EN         = 1'b1,
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv,
  input  logic       busy,
  output logic       int_side,
  output logic       meas_start,
  output logic       dvalid,
  output logic       meas_side,
  output logic       short_prep,
  output logic [3:0] state_num
);

  localparam logic INIT_SIDE = INVERT_CONV ? SIDE_B : SIDE_A;

  // reset: asynchronous assert, synchronous release
  logic [RST_SYNC_STAGES-1:0] rsync_q;
  logic                       rst_int_n;

  generate
    for (genvar g = 0; g < RST_SYNC_STAGES; g++) begin : g_rsync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rsync_q[g] <= 1'b0;
        end else begin
          if (g == 0) rsync_q[g] <= 1'b1;
          else        rsync_q[g] <= rsync_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign rst_int_n = rsync_q[RST_SYNC_STAGES-1];

  dsc_state_e state_q;
  logic       launch_enter, wait_exit, prep_enter, prep_exit, in_prep;

  dsc_fsm #(
    .INVERT_CONV (INVERT_CONV)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .conv         (conv),
    .busy         (busy),
    .state_q      (state_q),
    .launch_enter (launch_enter),
    .wait_exit    (wait_exit),
    .prep_enter   (prep_enter),
    .prep_exit    (prep_exit),
    .in_prep      (in_prep)
  );

  dsc_prep_timer #(
    .MIN_PREP_CLKS (MIN_PREP_CLKS),
    .WARN_EN       (WARN_EN)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .in_prep    (in_prep),
    .prep_enter (prep_enter),
    .prep_exit  (prep_exit),
    .short_prep (short_prep)
  );

  dsc_side_track #(
    .INIT_SIDE (INIT_SIDE)
  ) u_side (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .launch_enter (launch_enter),
    .wait_exit    (wait_exit),
    .int_side     (int_side),
    .meas_side    (meas_side),
    .meas_start   (meas_start),
    .dvalid       (dvalid)
  );

  assign state_num = state_q;

  // R9: state number stays within 1..8
  p_state_range_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_num >= 4'd1) && (state_num <= 4'd8));

  // R6: data-valid follows a low busy sample
  p_dv_busy_low_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    dvalid |-> !$past(busy));

  // R5: start request follows a conv edge level, never busy high
  p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    meas_start |-> !$past(busy));

endmodule

// File: tb/dualside_conv_seq_bench.sv
module dualside_conv_seq_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       conv;
    logic       busy;
    logic [3:0] st;
    logic       start;
    logic       dv;
    logic       side;
    logic       mside;
    logic       warn;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 16;
  // R2 R3 R4 R5 R6 R9 main walk from reset (state 1, side A)
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b0,4'd2,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2}, // R2 busy low leaves 1
    '{1'b0,1'b0,4'd2,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3}, // R3 conv low holds 2
    '{1'b1,1'b0,4'd3,1'b0,1'b0,1'b0,1'b0,1'b1,4'd3}, // R3 conv high -> 3
    '{1'b1,1'b0,4'd3,1'b0,1'b0,1'b0,1'b0,1'b0,4'd4}, // R4 holds 3
    '{1'b0,1'b0,4'd4,1'b1,1'b0,1'b1,1'b0,1'b0,4'd5}, // R5 launch, side B
    '{1'b0,1'b1,4'd1,1'b0,1'b0,1'b1,1'b0,1'b0,4'd5}, // R5 busy high -> 1
    '{1'b1,1'b1,4'd1,1'b0,1'b0,1'b1,1'b0,1'b0,4'd2}, // R2 conv ignored
    '{1'b0,1'b0,4'd2,1'b0,1'b1,1'b1,1'b0,1'b0,4'd6}, // R6 dvalid, side A data
    '{1'b1,1'b0,4'd3,1'b0,1'b0,1'b1,1'b0,1'b1,4'd3}, // R3 one-clock prep
    '{1'b0,1'b0,4'd4,1'b1,1'b0,1'b0,1'b1,1'b0,4'd5}, // R5 launch, side A
    '{1'b1,1'b0,4'd4,1'b0,1'b0,1'b0,1'b1,1'b0,4'd5}, // R5 conv ignored in 4
    '{1'b1,1'b1,4'd1,1'b0,1'b0,1'b0,1'b1,1'b0,4'd5}, // R5 -> 1
    '{1'b0,1'b1,4'd1,1'b0,1'b0,1'b0,1'b1,1'b0,4'd2}, // R2 holds 1
    '{1'b1,1'b0,4'd2,1'b0,1'b1,1'b0,1'b1,1'b0,4'd6}, // R6 dvalid, side B data
    '{1'b1,1'b0,4'd3,1'b0,1'b0,1'b0,1'b1,1'b1,4'd3}, // R3 immediate exit
    '{1'b0,1'b0,4'd4,1'b1,1'b0,1'b1,1'b0,1'b0,4'd9}  // R9 order 3,4,1,2,3,4
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv = 1'b0;
  logic busy = 1'b1;

  logic       n_side, n_start, n_dv, n_mside, n_warn;
  logic [3:0] n_state;
  logic       i_side, i_start, i_dv, i_mside, i_warn;
  logic [3:0] i_state;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dualside_conv_seq u_dualside_conv_seq (
    .clk (clk), .rst_n (rst_n), .conv (conv), .busy (busy),
    .int_side (n_side), .meas_start (n_start), .dvalid (n_dv),
    .meas_side (n_mside), .short_prep (n_warn), .state_num (n_state)
  );

  dualside_conv_seq #(.INVERT_CONV(1'b1)) u_dualside_conv_seq_inv (
    .clk (clk), .rst_n (rst_n), .conv (conv), .busy (busy),
    .int_side (i_side), .meas_start (i_start), .dvalid (i_dv),
    .meas_side (i_mside), .short_prep (i_warn), .state_num (i_state)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic b);
    @(negedge clk);
    conv = c;
    busy = b;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    conv  = 1'b0;
    busy  = 1'b1;
    #1;
    check("R1", "async state", n_state, 1);
    check("R1", "mirror async state", i_state, 8);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic prep_dwell(input int k, input int exp_warn);
    do_reset();
    step(1'b0, 1'b0);
    for (int i = 0; i < k - 1; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    check("R3", "state after prep", n_state, 3);
    check("R8", $sformatf("warn after %0d clk prep", k), n_warn, exp_warn);
  endtask

  initial begin
    do_reset();
    // R1 reset values
    check("R1", "state", n_state, 1);
    check("R1", "side", n_side, 0);
    check("R1", "start", n_start, 0);
    check("R1", "dvalid", n_dv, 0);
    check("R1", "meas_side", n_mside, 0);
    check("R1", "warn", n_warn, 0);
    check("R1", "mirror side", i_side, 1);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      step(VECS[v].conv, VECS[v].busy);
      tag = $sformatf("R%0d v%0d", VECS[v].req, v);
      check(tag, "state", n_state, VECS[v].st);
      check(tag, "start", n_start, VECS[v].start);
      check(tag, "dvalid", n_dv, VECS[v].dv);
      check(tag, "side", n_side, VECS[v].side);
      check(tag, "meas_side", n_mside, VECS[v].mside);
      check(tag, "warn", n_warn, VECS[v].warn);
    end

    // R1 asynchronous reset in the middle of integration
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    check("R1", "pre-reset state", n_state, 3);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "mid-run async state", n_state, 1);
    check("R1", "mid-run async side", n_side, 0);

    // R8 boundary of the preparation warning
    prep_dwell(15, 1);
    prep_dwell(16, 0);

    // R7 mirrored group
    do_reset();
    step(1'b1, 1'b0);
    check("R7", "8 -> 7", i_state, 7);
    step(1'b1, 1'b0);
    check("R7", "7 holds on high conv", i_state, 7);
    step(1'b0, 1'b0);
    check("R7", "7 -> 6 on low conv", i_state, 6);
    check("R8", "mirror short warn", i_warn, 1);
    step(1'b1, 1'b0);
    check("R7", "6 -> 5 on high conv", i_state, 5);
    check("R7", "mirror start", i_start, 1);
    check("R7", "mirror side A", i_side, 0);
    step(1'b1, 1'b1);
    check("R7", "5 -> 8", i_state, 8);
    step(1'b1, 1'b0);
    check("R7", "8 -> 7", i_state, 7);
    check("R7", "mirror dvalid", i_dv, 1);
    check("R7", "mirror meas_side B", i_mside, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule